// File: doc/BRIEF.md
# Store Width Adapter for Paged Register Space

This block sits between a processor's store port and a register space divided into 4 KB pages. It accepts stores of 8, 16, 32, 64 or 128 bits and converts each one into the access its target can take. One group of pages holds 128-bit FIFO write ports. A store of any width to those pages becomes a single 128-bit push, with the stored bytes placed in their own lane and every other byte set to zero. Ordinary registers are 32 bits wide. A store wider than that keeps only its low word. A store narrower than that is merged with the current contents through a read followed by a write.

Three kinds of target need special handling. A few write-one-to-act registers (status, mask and flag) must not be read back and merged, so a narrow store to them is shifted into position and written directly. A serial transmit register takes its data as single bytes in order, least significant first. The output FIFO on the last FIFO page drops stores without any notice. A store whose address is not aligned to its own size, or whose size code is not defined, raises a one-cycle error and has no other effect.

Top module: `store_width_adapter`

## Requirements
- R1: A store to FIFO page p (address bits [15:12] between 4 and 7) raises only `fifo_push[p-4]` for exactly the one cycle after acceptance. `fifo_data` holds the store's bytes starting at byte offset `st_addr[3:0]`, and all other bytes are zero. For a 32-bit store this puts the data in lane `st_addr[3:2]`.
- R2: A 64-bit store to a FIFO page pushes the data into the half chosen by `st_addr[3]` (0 selects bits 63:0, 1 selects bits 127:64), and the other half is zero.
- R3: A 128-bit store to a FIFO page pushes all 128 data bits unchanged.
- R4: On page 7, a store with `st_addr[4]` = 0 produces no push, no register access and no error. With `st_addr[4]` = 1 it pushes on `fifo_push[3]`.
- R5: A 64-bit (size 3) or 128-bit (size 4) store to a non-FIFO register issues a single 32-bit write of `st_data[31:0]` in the cycle after acceptance.
- R6: An 8-bit or 16-bit store to an ordinary register first raises `reg_rd_en` for the aligned word in the cycle after acceptance. In the next cycle it raises `reg_wr_en` with `reg_rdata`, where the addressed byte (`st_addr[1:0]`) or halfword (`st_addr[1]`) is replaced by the store data. `st_ready` stays low in both cycles.
- R7: An 8-bit or 16-bit store to a write-one register (word addresses 0xF000, 0xF010 and 0xE010 by default) does no read. It writes the zero-extended data shifted left by 8 times `st_addr[1:0]` in the cycle after acceptance.
- R8: A store to the transmit register (word 0xF180 by default) pushes 1, 2 or 4 bytes on `tx_push`/`tx_byte`: one byte for size 0, two for size 1 and four for larger sizes. One byte is pushed per cycle, least significant byte first, starting the cycle after acceptance. `st_ready` is low during every byte cycle.
- R9: A store with a size code above 4, or with an address not aligned to its size, raises `st_err` for one cycle and causes no push, no read and no write.
- R10: Coming out of reset, `st_ready` is high and every strobe (`fifo_push`, `reg_rd_en`, `reg_wr_en`, `tx_push`, `st_err`) is low.
- R11: A 32-bit store to an ordinary register writes `st_data[31:0]` to the word address in the cycle after acceptance. `st_ready` stays high for back-to-back stores.

Size codes: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit, 4 = 128-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store request accepted when high with valid |
| st_addr | input | 16 | Byte address of the store |
| st_size | input | 3 | Size code |
| st_data | input | 128 | Store data, right-justified |
| st_err | output | 1 | One-cycle pulse for a misaligned or undefined store |
| reg_rd_en | output | 1 | Register read strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_addr | output | 16 | Word-aligned register address |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, valid in the read cycle |
| fifo_push | output | 4 | Push strobe, one bit per FIFO |
| fifo_data | output | 128 | Zero-filled push data |
| tx_push | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |

## Verification
The assertions check, on every cycle, that the FIFO push strobes stay one-hot-or-idle and that a read is always followed by a write to the same word. They also check that the store port is held off during merge and transmit cycles, that an error pulse is never accompanied by any access, and that a store to the output FIFO yields nothing. The exact contents of a push lane, the merged word, the shifted write-one data and the order of the transmit bytes depend on the data, so only the bench's scenarios can confirm them.

// File: rtl/swa_pkg.sv
// Package: shared encodings for the store width adapter.
// Assumes size codes 0..4 stand for 1, 2, 4, 8 and 16 bytes.
package swa_pkg;
    localparam logic [2:0] SZ_B8   = 3'd0;
    localparam logic [2:0] SZ_B16  = 3'd1;
    localparam logic [2:0] SZ_B32  = 3'd2;
    localparam logic [2:0] SZ_B128 = 3'd4;

    // What a decoded store turns into
    typedef enum logic [2:0] {
        K_ERR,
        K_DROP,
        K_PUSH,
        K_TX,
        K_DIRECT,
        K_RMW
    } kind_t;

    // Sequencer state
    typedef enum logic [1:0] {
        S_IDLE,
        S_READ,
        S_WRITE,
        S_SEND
    } state_t;
endpackage

// File: rtl/swa_decode.sv
// Module: swa_decode
// Classifies one store request by page, register address and width, and
// prepares the 32-bit word for a direct write.
// Assumes the FIFO pages are contiguous and that address bits [11:0] lie within a page.
module swa_decode
    import swa_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int FIFO_FIRST = 4,
    parameter int NUM_FIFO   = 4,
    parameter int NUM_W1     = 3,
    parameter logic [ADDR_W-1:0] TX_ADDR = 16'hF180,
    parameter logic [NUM_W1*ADDR_W-1:0] W1_LIST = {16'hE010, 16'hF010, 16'hF000},
    localparam int SEL_W  = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1,
    localparam int PAGE_W = ADDR_W - 12
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic [31:0]       data,
    output kind_t             kind,
    output logic [SEL_W-1:0]  fifo_sel,
    output logic [2:0]        tx_count,
    output logic [31:0]       direct_word
);
    logic [PAGE_W-1:0] page;
    logic [3:0]        align_mask;
    logic              misaligned;
    logic              is_fifo;
    logic              is_tx;
    logic              sub_word;
    logic [NUM_W1-1:0] w1_hit;
    logic [31:0]       narrow;

    assign page = addr[ADDR_W-1:12];

    // One comparator per write-one register
    for (genvar i = 0; i < NUM_W1; i++) begin : g_w1
        assign w1_hit[i] = addr[ADDR_W-1:2] == W1_LIST[i*ADDR_W+2 +: ADDR_W-2];
    end

    // Alignment and target classification
    always_comb begin
        align_mask = 4'((5'd1 << size) - 5'd1);
        misaligned = (size > SZ_B128) || ((addr[3:0] & align_mask) != 4'd0);
        is_fifo    = (int'(page) >= FIFO_FIRST) && (int'(page) < FIFO_FIRST + NUM_FIFO);
        fifo_sel   = SEL_W'(int'(page) - FIFO_FIRST);
        is_tx      = addr[ADDR_W-1:2] == TX_ADDR[ADDR_W-1:2];
        sub_word   = size < SZ_B32;
        if (misaligned)
            kind = K_ERR;
        else if (is_fifo)
            kind = ((int'(fifo_sel) == NUM_FIFO - 1) && !addr[4]) ? K_DROP : K_PUSH;
        else if (is_tx)
            kind = K_TX;
        else if (sub_word && (w1_hit == '0))
            kind = K_RMW;
        else
            kind = K_DIRECT;
    end

    // Byte count for the transmit register
    always_comb begin
        case (size)
            SZ_B8:   tx_count = 3'd1;
            SZ_B16:  tx_count = 3'd2;
            default: tx_count = 3'd4;
        endcase
    end

    // Word for a direct write: shifted narrow data or the low word
    always_comb begin
        case (size)
            SZ_B8:   narrow = {24'h0, data[7:0]};
            SZ_B16:  narrow = {16'h0, data[15:0]};
            default: narrow = data;
        endcase
        direct_word = sub_word ? (narrow << {addr[1:0], 3'b000}) : data;
    end
endmodule

// File: rtl/swa_lane_fill.sv
// Module: swa_lane_fill
// Places a store's bytes in a 128-bit word from a byte offset upward and
// zeroes every other byte.
// Assumes the offset is aligned to the size, so no store crosses byte 15.
module swa_lane_fill (
    input  logic [127:0] data,
    input  logic [2:0]   size,
    input  logic [3:0]   off,
    output logic [127:0] lanes
);
    logic [4:0] nbytes;

    assign nbytes = 5'd1 << size;

    // One selector per output byte
    for (genvar b = 0; b < 16; b++) begin : g_byte
        localparam logic [4:0] BPOS = 5'(b);
        logic [3:0] idx;
        logic       en;
        assign idx = BPOS[3:0] - off;
        assign en  = (BPOS >= {1'b0, off}) && ({1'b0, idx} < nbytes);
        assign lanes[b*8 +: 8] = en ? data[{idx, 3'b000} +: 8] : 8'h00;
    end
endmodule

// File: rtl/swa_merge.sv
// Module: swa_merge
// Replaces one byte or one halfword of a read word with new store data.
// Assumes the offset is aligned to the width (halfwords use bit 1 only).
module swa_merge (
    input  logic [31:0] rdata,
    input  logic [15:0] sub,
    input  logic [1:0]  off,
    input  logic        half,
    output logic [31:0] merged
);
    // Overlay the new bytes on the old word
    always_comb begin
        merged = rdata;
        if (half)
            merged[{off[1], 4'b0000} +: 16] = sub;
        else
            merged[{off, 3'b000} +: 8] = sub[7:0];
    end
endmodule

// File: rtl/store_width_adapter.sv
// Module: store_width_adapter
// Converts 8..128-bit stores into FIFO pushes, 32-bit register writes,
// read-merge-write sequences or serial byte pushes. Every output is
// registered and appears in the cycle after the store is accepted.
// Assumes reg_rdata is valid in the same cycle as reg_rd_en.
module store_width_adapter
    import swa_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int FIFO_FIRST = 4,
    parameter int NUM_FIFO   = 4,
    parameter int NUM_W1     = 3,
    parameter logic [ADDR_W-1:0] TX_ADDR = 16'hF180,
    parameter logic [NUM_W1*ADDR_W-1:0] W1_LIST = {16'hE010, 16'hF010, 16'hF000},
    localparam int SEL_W = (NUM_FIFO > 1) ? $clog2(NUM_FIFO) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_valid,
    output logic                st_ready,
    input  logic [ADDR_W-1:0]   st_addr,
    input  logic [2:0]          st_size,
    input  logic [127:0]        st_data,
    output logic                st_err,
    output logic                reg_rd_en,
    output logic                reg_wr_en,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [31:0]         reg_wdata,
    input  logic [31:0]         reg_rdata,
    output logic [NUM_FIFO-1:0] fifo_push,
    output logic [127:0]        fifo_data,
    output logic                tx_push,
    output logic [7:0]          tx_byte
);
    state_t              state;
    kind_t               kind;
    logic [SEL_W-1:0]    fifo_sel;
    logic [2:0]          tx_count;
    logic [31:0]         direct_word;
    logic [127:0]        filled;
    logic [31:0]         merged;
    logic                accept;

    logic [NUM_FIFO-1:0] push_q;
    logic [127:0]        fdata_q;
    logic                wr_q;
    logic                err_q;
    logic [31:0]         wdata_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [15:0]         sub_q;
    logic [1:0]          off_q;
    logic                half_q;
    logic [31:0]         shift_q;
    logic [2:0]          left_q;

    swa_decode #(
        .ADDR_W(ADDR_W), .FIFO_FIRST(FIFO_FIRST), .NUM_FIFO(NUM_FIFO),
        .NUM_W1(NUM_W1), .TX_ADDR(TX_ADDR), .W1_LIST(W1_LIST)
    ) u_decode (
        .addr(st_addr), .size(st_size), .data(st_data[31:0]),
        .kind(kind), .fifo_sel(fifo_sel), .tx_count(tx_count),
        .direct_word(direct_word)
    );

    swa_lane_fill u_fill (
        .data(st_data), .size(st_size), .off(st_addr[3:0]), .lanes(filled)
    );

    swa_merge u_merge (
        .rdata(reg_rdata), .sub(sub_q), .off(off_q), .half(half_q), .merged(merged)
    );

    assign st_ready = state == S_IDLE;
    assign accept   = st_valid && st_ready;

    // Sequencer: launches single-cycle actions and steps multi-cycle ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            push_q  <= '0;
            fdata_q <= '0;
            wr_q    <= 1'b0;
            err_q   <= 1'b0;
            wdata_q <= '0;
            addr_q  <= '0;
            sub_q   <= '0;
            off_q   <= '0;
            half_q  <= 1'b0;
            shift_q <= '0;
            left_q  <= '0;
        end else begin
            push_q <= '0;
            wr_q   <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    addr_q <= {st_addr[ADDR_W-1:2], 2'b00};
                    case (kind)
                        K_ERR:    err_q <= 1'b1;
                        K_PUSH: begin
                            push_q  <= NUM_FIFO'(1) << fifo_sel;
                            fdata_q <= filled;
                        end
                        K_DIRECT: begin
                            wr_q    <= 1'b1;
                            wdata_q <= direct_word;
                        end
                        K_RMW: begin
                            state  <= S_READ;
                            sub_q  <= st_data[15:0];
                            off_q  <= st_addr[1:0];
                            half_q <= st_size == SZ_B16;
                        end
                        K_TX: begin
                            state   <= S_SEND;
                            shift_q <= st_data[31:0];
                            left_q  <= tx_count;
                        end
                        default: ;
                    endcase
                end
                S_READ: begin
                    wr_q    <= 1'b1;
                    wdata_q <= merged;
                    state   <= S_WRITE;
                end
                S_WRITE: state <= S_IDLE;
                S_SEND: begin
                    shift_q <= shift_q >> 8;
                    left_q  <= left_q - 3'd1;
                    if (left_q == 3'd1)
                        state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign st_err    = err_q;
    assign reg_rd_en = state == S_READ;
    assign reg_wr_en = wr_q;
    assign reg_addr  = addr_q;
    assign reg_wdata = wdata_q;
    assign fifo_push = push_q;
    assign fifo_data = fdata_q;
    assign tx_push   = state == S_SEND;
    assign tx_byte   = shift_q[7:0];
endmodule

// File: rtl/swa_checker.sv
// Module: swa_checker
// Cycle-level properties of the adapter's ports, bound to the top module.
// Assumes the same parameters as the instance it is bound to.
module swa_checker #(
    parameter int ADDR_W     = 16,
    parameter int FIFO_FIRST = 4,
    parameter int NUM_FIFO   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                st_valid,
    input logic                st_ready,
    input logic [ADDR_W-1:0]   st_addr,
    input logic                st_err,
    input logic                reg_rd_en,
    input logic                reg_wr_en,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [NUM_FIFO-1:0] fifo_push,
    input logic                tx_push
);
    localparam int PAGE_W = ADDR_W - 12;
    localparam logic [PAGE_W-1:0] LAST_PAGE = PAGE_W'(FIFO_FIRST + NUM_FIFO - 1);

    assert_push_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fifo_push));

    assert_drop_output_fifo_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_addr[ADDR_W-1:12] == LAST_PAGE && !st_addr[4])
        |=> (fifo_push == '0 && !reg_wr_en && !reg_rd_en && !tx_push));

    assert_word_address_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> reg_addr[1:0] == 2'b00);

    assert_read_then_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> (reg_wr_en && !reg_rd_en && reg_addr == $past(reg_addr)));

    assert_stall_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en || $past(reg_rd_en)) |-> !st_ready);

    assert_stall_on_send_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !st_ready);

    assert_error_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> (fifo_push == '0 && !reg_wr_en && !reg_rd_en && !tx_push));
endmodule

bind store_width_adapter swa_checker #(
    .ADDR_W(ADDR_W), .FIFO_FIRST(FIFO_FIRST), .NUM_FIFO(NUM_FIFO)
) u_swa_checker (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_err(st_err), .reg_rd_en(reg_rd_en),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .fifo_push(fifo_push),
    .tx_push(tx_push)
);

// File: tb/store_width_adapter_test.sv
`timescale 1ns/1ps
module store_width_adapter_test;
    localparam logic [15:0] TX_WORD = 16'hF180;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic         st_ready;
    logic [15:0]  st_addr = '0;
    logic [2:0]   st_size = '0;
    logic [127:0] st_data = '0;
    logic         st_err;
    logic         reg_rd_en;
    logic         reg_wr_en;
    logic [15:0]  reg_addr;
    logic [31:0]  reg_wdata;
    logic [31:0]  reg_rdata = '0;
    logic [3:0]   fifo_push;
    logic [127:0] fifo_data;
    logic         tx_push;
    logic [7:0]   tx_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    store_width_adapter uut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_size(st_size), .st_data(st_data), .st_err(st_err),
        .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_push(fifo_push),
        .fifo_data(fifo_data), .tx_push(tx_push), .tx_byte(tx_byte)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_w1(input logic [15:0] a);
        return (a[15:2] == 14'(16'hF000 >> 2)) || (a[15:2] == 14'(16'hF010 >> 2)) ||
               (a[15:2] == 14'(16'hE010 >> 2));
    endfunction

    function automatic logic [127:0] zero_fill(input logic [15:0] a, input logic [2:0] sz, input logic [127:0] d);
        logic [127:0] r = '0;
        for (int k = 0; k < (1 << sz); k++)
            r[(int'(a[3:0]) + k) * 8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    // Issue one store at a falling edge and check every resulting cycle
    task automatic run_store(input logic [15:0] a, input logic [2:0] sz, input logic [127:0] d, input logic [31:0] rdv);
        int nb;
        bit mis;
        logic [3:0] page;
        logic [15:0] word;
        logic [31:0] m;
        logic [127:0] e;
        nb   = (sz <= 3'd4) ? (1 << sz) : 0;
        mis  = (sz > 3'd4) || ((int'(a[3:0]) & (nb - 1)) != 0);
        page = a[15:12];
        word = {a[15:2], 2'b00};
        st_addr = a; st_size = sz; st_data = d; st_valid = 1'b1;
        @(negedge clk);
        st_valid = 1'b0;
        if (mis) begin
            chk(st_err && fifo_push == 0 && !reg_wr_en && !reg_rd_en && !tx_push && st_ready,
                "R9 error only", {st_err, fifo_push, reg_wr_en, reg_rd_en}, {1'b1, 7'b0});
        end else if (page >= 4'd4 && page <= 4'd7) begin
            if (page == 4'd7 && !a[4]) begin
                chk(fifo_push == 0 && !reg_wr_en && !reg_rd_en && !st_err && !tx_push,
                    "R4 output fifo dropped", {fifo_push, reg_wr_en, st_err}, 0);
            end else begin
                e = zero_fill(a, sz, d);
                chk(fifo_push == 4'(1 << (page - 4'd4)), "R1 push strobe", fifo_push, 4'(1 << (page - 4'd4)));
                if (sz == 3'd3)      chk(fifo_data == e, "R2 half fill", fifo_data, e);
                else if (sz == 3'd4) chk(fifo_data == e, "R3 full push", fifo_data, e);
                else                 chk(fifo_data == e, "R1 lane fill", fifo_data, e);
            end
        end else if (a[15:2] == TX_WORD[15:2]) begin
            nb = (sz == 3'd0) ? 1 : (sz == 3'd1) ? 2 : 4;
            for (int k = 0; k < nb; k++) begin
                chk(tx_push && tx_byte == d[k*8 +: 8] && !st_ready, "R8 tx byte",
                    {tx_push, tx_byte, st_ready}, {1'b1, d[k*8 +: 8], 1'b0});
                @(negedge clk);
            end
            chk(st_ready && !tx_push, "R8 tx end", {st_ready, tx_push}, 2'b10);
        end else if (sz < 3'd2 && is_w1(a)) begin
            m = (sz == 3'd0) ? {24'h0, d[7:0]} : {16'h0, d[15:0]};
            m = m << (8 * int'(a[1:0]));
            chk(reg_wr_en && !reg_rd_en && reg_addr == word && reg_wdata == m, "R7 shifted write",
                {reg_wr_en, reg_rd_en, reg_addr, reg_wdata}, {1'b1, 1'b0, word, m});
        end else if (sz < 3'd2) begin
            chk(reg_rd_en && !reg_wr_en && !st_ready && reg_addr == word, "R6 read cycle",
                {reg_rd_en, reg_wr_en, st_ready, reg_addr}, {3'b100, word});
            reg_rdata = rdv;
            @(negedge clk);
            m = rdv;
            if (sz == 3'd0) m[8 * int'(a[1:0]) +: 8] = d[7:0];
            else            m[16 * int'(a[1]) +: 16] = d[15:0];
            chk(reg_wr_en && !reg_rd_en && !st_ready && reg_addr == word && reg_wdata == m, "R6 merged write",
                {reg_wr_en, reg_rd_en, st_ready, reg_addr, reg_wdata}, {3'b100, word, m});
            @(negedge clk);
            chk(st_ready && !reg_wr_en, "R6 release", {st_ready, reg_wr_en}, 2'b10);
        end else begin
            chk(reg_wr_en && !reg_rd_en && st_ready && reg_addr == word && reg_wdata == d[31:0],
                (sz >= 3'd3) ? "R5 truncated write" : "R11 word write",
                {reg_wr_en, reg_rd_en, st_ready, reg_addr, reg_wdata}, {3'b101, word, d[31:0]});
        end
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        int seed_val;
        logic [15:0] a;
        logic [2:0]  sz;
        logic [3:0]  pg;
        seed_val = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(st_ready && fifo_push == 0 && !reg_rd_en && !reg_wr_en && !tx_push && !st_err,
            "R10 reset state", {st_ready, fifo_push, reg_rd_en, reg_wr_en, tx_push, st_err}, {1'b1, 8'b0});
        rst_n = 1'b1;
        @(negedge clk);
        chk(st_ready && fifo_push == 0 && !reg_wr_en, "R10 after reset", {st_ready, fifo_push}, {1'b1, 4'b0});

        // Directed corners
        for (int l = 0; l < 4; l++) run_store(16'h4000 | 16'(l * 4), 3'd2, rnd128(), 0);  // R1 lanes
        run_store(16'h5000, 3'd3, rnd128(), 0);                 // R2 low half
        run_store(16'h5008, 3'd3, rnd128(), 0);                 // R2 high half
        run_store(16'h6000, 3'd4, rnd128(), 0);                 // R3
        run_store(16'h7000, 3'd4, rnd128(), 0);                 // R4 dropped
        run_store(16'h7004, 3'd2, rnd128(), 0);                 // R4 dropped, narrow
        run_store(16'h7010, 3'd2, rnd128(), 0);                 // R4 input fifo
        run_store(16'h7013, 3'd0, rnd128(), 0);                 // R1 byte lane
        run_store(16'h1040, 3'd3, rnd128(), 0);                 // R5
        run_store(16'h2050, 3'd4, rnd128(), 0);                 // R5
        run_store(16'h3003, 3'd0, 128'hA5, 32'h11223344);       // R6 byte 3
        run_store(16'h3002, 3'd1, 128'hBEEF, 32'h55667788);     // R6 upper half
        run_store(16'hF012, 3'd0, 128'h81, 0);                  // R7
        run_store(16'hE012, 3'd1, 128'hC00F, 0);                // R7
        run_store(TX_WORD, 3'd2, 128'h44332211, 0);             // R8 four bytes
        run_store(TX_WORD, 3'd0, 128'h5A, 0);                   // R8 one byte
        run_store(16'h1002, 3'd2, rnd128(), 0);                 // R9 misaligned
        run_store(16'h1000, 3'd5, rnd128(), 0);                 // R9 bad size
        run_store(16'h4008, 3'd4, rnd128(), 0);                 // R9 misaligned wide
        run_store(16'h0ff0, 3'd2, rnd128(), 0);                 // R11
        run_store(16'h0ff4, 3'd2, rnd128(), 0);                 // R11 back to back

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            sz = 3'($urandom % 5);
            case ($urandom % 6)
                0: begin pg = 4'(4 + $urandom % 4); a = {pg, 12'($urandom)}; end
                1: a = TX_WORD | 16'($urandom % 4);
                2: begin
                    case ($urandom % 3)
                        0: a = 16'hF000; 1: a = 16'hF010; default: a = 16'hE010;
                    endcase
                    a = a | 16'($urandom % 4);
                end
                3: begin sz = 3'($urandom % 8); a = 16'($urandom); end
                default: begin
                    pg = 4'($urandom % 10);
                    if (pg >= 4'd4) pg = pg + 4'd4;
                    a = {pg, 12'($urandom)};
                end
            endcase
            if ($urandom % 8 != 0 && sz <= 3'd4) a = a & ~16'((1 << sz) - 1);
            run_store(a, sz, rnd128(), $urandom);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule